// File: doc/BRIEF.md
# Variable-Page-Size Associative Translation Buffer

This block translates virtual addresses into physical addresses through a fully associative table of 64 entries. Every entry pairs a 64-bit tag, which carries a virtual page number and a 13-bit address-space context, with a 64-bit translation word. The translation word gives the physical page, a two-bit page-size code (8 KB, 64 KB, 512 KB or 4 MB) and the permission flags. A lookup compares its virtual address and the current context against all entries at once. Each entry masks the address at its own page size.

One lookup port serves both the instruction side and the data side, selected per request. A lookup yields either a physical address with its permissions, a miss, or a fault. Faults cover an invalid entry, a user access to a privileged page, and a data write to a read-only page. Each side keeps a 4-bit fault status register with an overflow marker, and the data side also captures the faulting address. When a side's enable input is low, its addresses pass through untranslated. Entries are loaded through a simple indexed write port. Refill and replacement policy are left to the surrounding logic.

Top module: `vps_tlb`

## Requirements
- R1: After reset all result outputs, both fault status registers and the fault address are zero, and every stored tag and translation word is zero.
- R2: An entry matches when tag bits 12:0 equal `ctx` and the virtual address, masked by the entry's page size, equals the tag with bits 12:0 cleared. The size code is in translation bits 62:61: 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB.
- R3: On a clean hit, `res_pa` = (word & sizemask & 0x1FFFFFFF000) | (va & ~sizemask & 0x1FFFFFFF000). `res_wr` shows translation bit 1 and `res_lock` shows bit 6.
- R4: When no entry matches on an enabled side, `res_miss` is 1, `res_fault` is 0 and `res_pa` is 0.
- R5: A matching entry whose translation bit 63 (valid) is 0 produces a fault. After reset, a context-0 lookup in page 0 therefore faults.
- R6: A user lookup (`lk_user`=1) that matches an entry with translation bit 2 (privileged) set produces a fault.
- R7: A data write (`lk_side`=0, `lk_write`=1) that matches an entry with bit 1 clear produces a fault. On the instruction side (`lk_side`=1) `lk_write` has no effect.
- R8: On a fault, the selected side's status register becomes ((old != 0) ? 2 : 0) | (user<<3) | (write<<2) | 1, where write is 0 on the instruction side. `fsr_clr_*` zeroes the register, and a fault in the same cycle is applied on top of the cleared value.
- R9: A data-side fault loads `fault_addr` with the lookup address. Nothing else changes `fault_addr`.
- R10: When the selected side's enable is low, the lookup returns `res_pa` = va with no miss and no fault. `res_wr` is 1 on the data side and 0 on the instruction side.
- R11: When several entries match, the lowest index decides the result.
- R12: A result appears in the cycle after `lk_valid`, with `res_valid` high for exactly that cycle. A write in the same cycle as a lookup is not visible to that lookup, only to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag: virtual page bits and context in 12:0 |
| wr_word | input | 64 | Translation word |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | 1 = instruction side, 0 = data side |
| lk_va | input | 64 | Virtual address |
| lk_write | input | 1 | Data write access |
| lk_user | input | 1 | Unprivileged access |
| ctx | input | 13 | Current context |
| en_instr | input | 1 | Translation enable, instruction side |
| en_data | input | 1 | Translation enable, data side |
| fsr_clr_i | input | 1 | Clear instruction fault status |
| fsr_clr_d | input | 1 | Clear data fault status |
| res_valid | output | 1 | Result valid |
| res_miss | output | 1 | No entry matched |
| res_fault | output | 1 | Protection or validity fault |
| res_pa | output | 64 | Physical address |
| res_wr | output | 1 | Page writable |
| res_lock | output | 1 | Entry locked flag |
| fsr_instr | output | 4 | Instruction fault status |
| fsr_data | output | 4 | Data fault status |
| fault_addr | output | 64 | Last data fault address |

## Verification
The bench targets a context mismatch on an otherwise matching page. A design that skips the context compare returns a hit there instead of a miss. It also overlaps two matching entries, so a priority encoder scanning from the wrong end returns the other physical page. Faults are issued back to back to reach the overflow encoding 2|bits, and an instruction-side write to a read-only page is expected to pass. Random lookups land at offsets across all four page sizes, so a wrong size mask shows up as either a miss or the wrong physical bits. One lookup shares its cycle with a write to a matching entry and must still miss, which exposes a write-through path.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned CTX_W    = 13;
  localparam logic [WORD_W-1:0] PA_FIELD = 64'h0000_01FF_FFFF_F000;
  localparam logic [WORD_W-1:0] CTX_BITS = 64'h0000_0000_0000_1FFF;

  localparam int unsigned B_VALID = 63;
  localparam int unsigned B_SZ_HI = 62;
  localparam int unsigned B_SZ_LO = 61;
  localparam int unsigned B_LOCK  = 6;
  localparam int unsigned B_PRIV  = 2;
  localparam int unsigned B_WRITE = 1;

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } pg_size_e;

  function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] sz);
    case (pg_size_e'(sz))
      PG_8K:   page_mask = ~64'h0000_0000_0000_1FFF;
      PG_64K:  page_mask = ~64'h0000_0000_0000_FFFF;
      PG_512K: page_mask = ~64'h0000_0000_0007_FFFF;
      default: page_mask = ~64'h0000_0000_003F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/vps_tlb_match.sv
module vps_tlb_match
  import vps_tlb_pkg::*;
(
  input  logic [WORD_W-1:0] tag,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] va,
  input  logic [CTX_W-1:0]  ctx,
  output logic              hit
);
  logic [WORD_W-1:0] mask;
  logic              ctx_eq;
  logic              page_eq;

  assign mask    = page_mask(word[B_SZ_HI:B_SZ_LO]);
  assign ctx_eq  = (tag[CTX_W-1:0] == ctx);
  assign page_eq = ((va & mask) == (tag & ~CTX_BITS));
  assign hit     = ctx_eq && page_eq;
endmodule

// File: rtl/vps_tlb_prio.sv
module vps_tlb_prio #(
  parameter int unsigned N = 64,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vps_tlb_fsr.sv
module vps_tlb_fsr (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       fault,
  input  logic       user,
  input  logic       wr,
  output logic [3:0] fsr
);
  logic [3:0] base;
  logic [3:0] ovf;

  assign base = clr ? 4'd0 : fsr;
  assign ovf  = (base != 4'd0) ? 4'd2 : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr <= 4'd0;
    end else if (fault) begin
      fsr <= ovf | {user, wr, 1'b0, 1'b1};
    end else begin
      fsr <= base;
    end
  end
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [63:0]       wr_tag,
  input  logic [63:0]       wr_word,
  input  logic              lk_valid,
  input  logic              lk_side,
  input  logic [63:0]       lk_va,
  input  logic              lk_write,
  input  logic              lk_user,
  input  logic [12:0]       ctx,
  input  logic              en_instr,
  input  logic              en_data,
  input  logic              fsr_clr_i,
  input  logic              fsr_clr_d,
  output logic              res_valid,
  output logic              res_miss,
  output logic              res_fault,
  output logic [63:0]       res_pa,
  output logic              res_wr,
  output logic              res_lock,
  output logic [3:0]        fsr_instr,
  output logic [3:0]        fsr_data,
  output logic [63:0]       fault_addr
);
  logic [WORD_W-1:0] tag_q  [ENTRIES];
  logic [WORD_W-1:0] word_q [ENTRIES];

  // entry storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        word_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      word_q[wr_idx] <= wr_word;
    end
  end

  // parallel compare
  logic [ENTRIES-1:0] hits;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    vps_tlb_match u_match (
      .tag  (tag_q[g]),
      .word (word_q[g]),
      .va   (lk_va),
      .ctx  (ctx),
      .hit  (hits[g])
    );
  end

  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  vps_tlb_prio #(.N(ENTRIES)) u_prio (
    .req (hits),
    .idx (win_idx),
    .any (win_any)
  );

  // result formation
  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] sel_mask;
  logic              side_en;
  logic              eff_wr;
  logic              n_miss, n_fault, n_wr, n_lock;
  logic [WORD_W-1:0] n_pa;

  assign sel_word = word_q[win_idx];
  assign sel_mask = page_mask(sel_word[B_SZ_HI:B_SZ_LO]);
  assign side_en  = lk_side ? en_instr : en_data;
  assign eff_wr   = lk_write && !lk_side;

  always_comb begin
    n_miss  = 1'b0;
    n_fault = 1'b0;
    n_wr    = 1'b0;
    n_lock  = 1'b0;
    n_pa    = '0;
    if (!side_en) begin
      n_pa = lk_va;
      n_wr = !lk_side;
    end else if (!win_any) begin
      n_miss = 1'b1;
    end else if (!sel_word[B_VALID] ||
                 (sel_word[B_PRIV] && lk_user) ||
                 (eff_wr && !sel_word[B_WRITE])) begin
      n_fault = 1'b1;
    end else begin
      n_pa   = (sel_word & sel_mask & PA_FIELD) | (lk_va & ~sel_mask & PA_FIELD);
      n_wr   = sel_word[B_WRITE];
      n_lock = sel_word[B_LOCK];
    end
  end

  logic side_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_pa    <= '0;
      res_wr    <= 1'b0;
      res_lock  <= 1'b0;
      side_q    <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_miss  <= n_miss;
        res_fault <= n_fault;
        res_pa    <= n_pa;
        res_wr    <= n_wr;
        res_lock  <= n_lock;
        side_q    <= lk_side;
      end
    end
  end

  // fault status per side
  logic fault_i, fault_d;
  assign fault_i = lk_valid && n_fault && lk_side;
  assign fault_d = lk_valid && n_fault && !lk_side;

  vps_tlb_fsr u_fsr_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (fsr_clr_i),
    .fault (fault_i),
    .user  (lk_user),
    .wr    (1'b0),
    .fsr   (fsr_instr)
  );

  vps_tlb_fsr u_fsr_d (
    .clk   (clk),
    .rst   (rst),
    .clr   (fsr_clr_d),
    .fault (fault_d),
    .user  (lk_user),
    .wr    (lk_write),
    .fsr   (fsr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_addr <= '0;
    end else if (fault_d) begin
      fault_addr <= lk_va;
    end
  end
endmodule

// File: rtl/vps_tlb_chk.sv
module vps_tlb_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic        lk_side,
  input logic [63:0] lk_va,
  input logic        en_instr,
  input logic        en_data,
  input logic        res_valid,
  input logic        res_miss,
  input logic        res_fault,
  input logic [63:0] res_pa,
  input logic [3:0]  fsr_instr,
  input logic [3:0]  fsr_data,
  input logic [63:0] fault_addr,
  input logic        side_q
);
  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R4
  miss_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_miss && res_fault));
  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !(lk_side ? en_instr : en_data)) |=>
      (!res_miss && !res_fault && res_pa == $past(lk_va)));
  // R8
  fsr_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault && side_q) |-> fsr_instr[0]);
  // R8
  fsr_data_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault && !side_q) |-> fsr_data[0]);
  // R9
  far_load_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault && !side_q) |-> fault_addr == $past(lk_va));
  // R9
  far_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_fault && !side_q) |-> $stable(fault_addr));
endmodule

bind vps_tlb vps_tlb_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_side    (lk_side),
  .lk_va      (lk_va),
  .en_instr   (en_instr),
  .en_data    (en_data),
  .res_valid  (res_valid),
  .res_miss   (res_miss),
  .res_fault  (res_fault),
  .res_pa     (res_pa),
  .fsr_instr  (fsr_instr),
  .fsr_data   (fsr_data),
  .fault_addr (fault_addr),
  .side_q     (side_q)
);

// File: tb/test_vps_tlb.sv
module test_vps_tlb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        wr_en = 0;
  logic [5:0]  wr_idx = 0;
  logic [63:0] wr_tag = 0, wr_word = 0;
  logic        lk_valid = 0, lk_side = 0, lk_write = 0, lk_user = 0;
  logic [63:0] lk_va = 0;
  logic [12:0] ctx = 0;
  logic        en_instr = 1, en_data = 1, fsr_clr_i = 0, fsr_clr_d = 0;
  logic        res_valid, res_miss, res_fault, res_wr, res_lock;
  logic [63:0] res_pa, fault_addr;
  logic [3:0]  fsr_instr, fsr_data;

  vps_tlb i_vps_tlb (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] mtag [64];
  logic [63:0] mword [64];
  logic [3:0]  m_fi, m_fd;
  logic [63:0] m_far;

  function automatic logic [63:0] szmask(input logic [1:0] s);
    case (s)
      2'd0: return 64'hFFFF_FFFF_FFFF_E000;
      2'd1: return 64'hFFFF_FFFF_FFFF_0000;
      2'd2: return 64'hFFFF_FFFF_FFF8_0000;
      default: return 64'hFFFF_FFFF_FFC0_0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [63:0] t, input logic [63:0] w);
    wr_en = 1; wr_idx = 6'(idx); wr_tag = t; wr_word = w;
    @(negedge clk);
    wr_en = 0;
    mtag[idx] = t; mword[idx] = w;
  endtask

  // Lookup with expected result from the requirement model; optional same-cycle write
  task automatic lookup(input logic [63:0] va, input logic [12:0] c, input bit side,
                        input bit wrt, input bit usr, input string req,
                        input bit do_wr = 0, input int widx = 0,
                        input logic [63:0] wt = 0, input logic [63:0] ww = 0);
    bit e_miss, e_fault, e_wr, e_lock, found, en;
    logic [63:0] e_pa, w, m;
    e_miss = 0; e_fault = 0; e_wr = 0; e_lock = 0; e_pa = 0; found = 0;
    en = side ? en_instr : en_data;
    if (!en) begin
      e_pa = va; e_wr = !side;                           // R10
    end else begin
      for (int i = 0; i < 64 && !found; i++) begin       // R11 lowest first
        m = szmask(mword[i][62:61]);
        if (mtag[i][12:0] == c && (va & m) == (mtag[i] & ~64'h1FFF)) begin
          found = 1; w = mword[i];
        end
      end
      if (!found) e_miss = 1;                            // R4
      else begin
        m = szmask(w[62:61]);
        if (!w[63] || (w[2] && usr) || (!side && wrt && !w[1])) e_fault = 1;
        else begin
          e_pa = (w & m & 64'h1FF_FFFF_F000) | (va & ~m & 64'h1FF_FFFF_F000);
          e_wr = w[1]; e_lock = w[6];
        end
      end
    end
    if (e_fault) begin                                   // R8, R9
      if (side) m_fi = ((m_fi != 0) ? 4'd2 : 4'd0) | {usr, 1'b0, 1'b0, 1'b1};
      else begin
        m_fd = ((m_fd != 0) ? 4'd2 : 4'd0) | {usr, wrt, 1'b0, 1'b1};
        m_far = va;
      end
    end
    lk_valid = 1; lk_va = va; ctx = c; lk_side = side; lk_write = wrt; lk_user = usr;
    if (do_wr) begin wr_en = 1; wr_idx = 6'(widx); wr_tag = wt; wr_word = ww; end
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    if (do_wr) begin mtag[widx] = wt; mword[widx] = ww; end
    check(res_valid && res_miss == e_miss && res_fault == e_fault && res_pa == e_pa &&
          res_wr == e_wr && res_lock == e_lock && fsr_instr == m_fi && fsr_data == m_fd &&
          fault_addr == m_far, req,
          $sformatf("v%0b m%0b f%0b pa=%h w%0b l%0b fi=%h fd=%h far=%h", res_valid, res_miss,
                    res_fault, res_pa, res_wr, res_lock, fsr_instr, fsr_data, fault_addr),
          $sformatf("v1 m%0b f%0b pa=%h w%0b l%0b fi=%h fd=%h far=%h", e_miss, e_fault, e_pa,
                    e_wr, e_lock, m_fi, m_fd, m_far));
  endtask

  task automatic clear_fsr;
    fsr_clr_i = 1; fsr_clr_d = 1;
    @(negedge clk);
    fsr_clr_i = 0; fsr_clr_d = 0;
    m_fi = 0; m_fd = 0;
  endtask

  function automatic logic [63:0] mk_word(input bit v, input logic [1:0] sz, input logic [63:0] pa,
                                          input bit lk, input bit pv, input bit wr);
    return {v, sz, 61'd0} | (pa & 64'h1FF_FFFF_E000) | {57'd0, lk, 3'd0, pv, wr, 1'b0};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] va, t, w;
    int k;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin mtag[i] = 0; mword[i] = 0; end
    m_fi = 0; m_fd = 0; m_far = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!res_valid && !res_miss && !res_fault && res_pa == 0 && !res_wr && !res_lock &&
          fsr_instr == 0 && fsr_data == 0 && fault_addr == 0, "R1",
          $sformatf("pa=%h fi=%h fd=%h far=%h", res_pa, fsr_instr, fsr_data, fault_addr), "all zero");
    // R5 zeroed entries match context 0 page 0 and fault; R8 overflow on second fault
    lookup(64'h0000_0000_0000_0123, 13'd0, 0, 0, 0, "R5");
    lookup(64'h0000_0000_0000_0456, 13'd0, 0, 1, 1, "R8");
    check(fsr_data == 4'hF, "R8", $sformatf("%h", fsr_data), "f");
    lookup(64'h0000_0000_0000_0010, 13'd0, 1, 1, 0, "R9");   // instr fault, far unchanged
    clear_fsr();
    check(fsr_data == 0 && fsr_instr == 0, "R8", $sformatf("%h/%h", fsr_data, fsr_instr), "0/0");
    // park all entries in an unused context
    for (int i = 0; i < 64; i++) write_entry(i, 64'h1FFF, 64'd0);
    lookup(64'h0000_0000_0000_0123, 13'd0, 0, 0, 0, "R4");
    // R2/R3 4 MB page
    write_entry(5, 64'h0000_0000_4000_0005, mk_word(1, 2'd3, 64'h0000_0123_4000_0000, 1, 0, 1));
    lookup(64'h0000_0000_4012_3456, 13'd5, 0, 1, 1, "R3");
    lookup(64'h0000_0000_4012_3456, 13'd6, 0, 0, 0, "R2");   // context mismatch -> miss
    lookup(64'h0000_0000_4412_3456, 13'd5, 0, 0, 0, "R2");   // outside page -> miss
    // R11 overlap: entries 10 and 20
    write_entry(20, 64'h0000_0000_0080_0002, mk_word(1, 2'd1, 64'h0000_0000_AAAA_0000, 0, 0, 1));
    write_entry(10, 64'h0000_0000_0080_0002, mk_word(1, 2'd0, 64'h0000_0000_5554_0000, 0, 0, 0));
    lookup(64'h0000_0000_0080_1234, 13'd2, 0, 0, 0, "R11");
    // R7 read-only write faults on data, passes on instruction side
    lookup(64'h0000_0000_0080_1234, 13'd2, 0, 1, 0, "R7");
    lookup(64'h0000_0000_0080_1234, 13'd2, 1, 1, 0, "R7");
    // R6 privileged page
    write_entry(7, 64'h0000_0000_0100_0003, mk_word(1, 2'd2, 64'h0000_0000_0700_0000, 0, 1, 1));
    lookup(64'h0000_0000_0107_0000, 13'd3, 1, 0, 1, "R6");
    lookup(64'h0000_0000_0107_0000, 13'd3, 0, 0, 0, "R6");
    // R10 bypass
    en_data = 0;
    lookup(64'hDEAD_BEEF_0000_1234, 13'd3, 0, 1, 1, "R10");
    en_data = 1; en_instr = 0;
    lookup(64'h1234_5678_9ABC_DEF0, 13'd3, 1, 0, 1, "R10");
    en_instr = 1;
    // R12 same-cycle write invisible to that lookup
    lookup(64'h0000_0000_0300_0000, 13'd4, 0, 0, 0, "R12", 1, 30,
           64'h0000_0000_0300_0004, mk_word(1, 2'd0, 64'h0000_0000_0999_0000, 0, 0, 1));
    lookup(64'h0000_0000_0300_0000, 13'd4, 0, 0, 0, "R12");
    clear_fsr();
    // random phase
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 9) < 3) begin
        logic [1:0] sz;
        sz = 2'($urandom_range(0, 3));
        va = {$urandom, $urandom} & 64'h0000_0000_0FFF_FFFF & szmask(sz);
        t = va | 64'($urandom_range(1, 3));
        w = mk_word($urandom_range(0, 9) != 0, sz, {$urandom, $urandom},
                    1'($urandom), $urandom_range(0, 3) == 0, 1'($urandom));
        write_entry($urandom_range(0, 63), t, w);
      end else begin
        k = $urandom_range(0, 63);
        if ($urandom_range(0, 4) == 0) va = {$urandom, $urandom} & 64'h0000_0000_0FFF_FFFF;
        else va = (mtag[k] & ~64'h1FFF) | ({$urandom, $urandom} & ~szmask(mword[k][62:61]));
        if ($urandom_range(0, 15) == 0) en_data = ~en_data;
        if ($urandom_range(0, 15) == 0) en_instr = ~en_instr;
        if ($urandom_range(0, 20) == 0) clear_fsr();
        lookup(va, ($urandom_range(0, 4) == 0) ? 13'($urandom_range(1, 3)) : mtag[k][12:0],
               1'($urandom), 1'($urandom), 1'($urandom), "R3 R11 random");
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule